// File: doc/BRIEF.md
# Two-Tier Register-Mapped Interrupt Controller

This block gathers fifteen peripheral interrupt request lines, numbered 1 to 15, and presents each of a parameterised number of processors with a 4-bit interrupt level. A request is captured on the rising edge of its line. It lands either in a pending register shared by all processors or, when the line is marked for broadcast, in the force register of every processor. For each processor, the lines that may reach it are the pending bits and its own force bits, filtered by its own mask.

Each line carries one programmable priority bit, which places it in either a high tier or a low tier. A processor is shown the highest-numbered active line in the high tier. Only when no high-tier line is active is it shown the highest-numbered active line in the low tier. An acknowledge from a processor names the interrupt it has taken. That number is cleared from the pending register and from that processor's force register.

Software reaches every register over a 32-bit word-wide register bus with an 8-bit byte address. Reads are combinational. Writes take effect at the next clock edge.

Top module: `tier_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and every processor level output is 0.
- R2: Bit 0 is never an interrupt. All writable interrupt registers store only bits 15:1 of the write data, so bit 0 and bits 31:16 read back as zero. The priority register is at offset 0x00; a 1 in bit k puts line k in the high tier.
- R3: A 0-to-1 change of line k, sampled at the clock, sets pending bit k when broadcast bit k is 0. A line held high sets nothing further. Pending reads at offset 0x04.
- R4: A rising edge on line k whose broadcast bit is 1 sets force bit k of every processor and leaves pending unchanged. The broadcast register is at offset 0x14.
- R5: The active set of processor n is (pending OR force n) AND mask n, with mask n at offset 0x40+4n. The level output is the highest-numbered line of the chosen tier, or 0 when nothing is active.
- R6: Active lines in the high tier win over all active lines in the low tier.
- R7: A write to force n at offset 0x80+4n computes new = (old OR data[15:1]) AND NOT data[31:17].
- R8: A write to offset 0x08 replaces force 0 with data[15:1]. A read of offset 0x08 returns force 0.
- R9: A write to offset 0x0C clears the written bits in pending. A rising edge on a line in the same cycle keeps that line's pending bit set.
- R10: Offsets 0x0C and 0x10 read zero. Writes to 0x04 and 0x10 are ignored. Unmapped or misaligned offsets, and per-processor offsets with n not below the processor count, read zero and ignore writes.
- R11: An acknowledge with number k from processor n clears pending bit k and force n bit k, and leaves the force bits of other processors alone. A rising edge on line k in the same cycle wins.
- R12: Per-processor extended registers at 0xC0+4n store data[3:0] and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines, bit k is line k; bit 0 ignored |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ack_valid | input | NCPU | Per-processor acknowledge strobe |
| ack_num | input | 4*NCPU | Acknowledged interrupt number, 4 bits per processor |
| cpu_level | output | 4*NCPU | Interrupt level per processor, 4 bits each |

## Verification
The assertions assume that the request lines are synchronous to the clock and hold steady around each edge. They also assume that an acknowledge number, when its strobe is high, names a line from 1 to 15. The bench changes every input only at the falling edge. It toggles request lines one at a time at random. It draws acknowledge numbers from 0 to 15, and the design treats number 0 as harmless.

// File: rtl/tier_irq_ctrl.sv
module tier_irq_ctrl #(
  parameter int NCPU = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCPU-1:0]   ack_valid,
  input  logic [NCPU*4-1:0] ack_num,
  output logic [NCPU*4-1:0] cpu_level
);
  localparam logic [15:0] LMASK = 16'hFFFE;

  logic [15:0] lvl_q, pend_q, bc_q, irq_q;
  logic [15:0] msk_q [NCPU];
  logic [15:0] frc_q [NCPU];
  logic [3:0]  ext_q [NCPU];
  logic [15:0] frc_d [NCPU];
  logic [15:0] ack_oh [NCPU];
  logic [15:0] act_w [NCPU];
  logic [15:0] ack_any, clr_w;

  wire        wr_en   = bus_sel & bus_wr;
  wire [15:0] wd      = bus_wdata[15:0] & LMASK;
  wire [15:0] wclr    = bus_wdata[31:16] & LMASK;
  wire [15:0] rise    = irq_in & ~irq_q & LMASK;
  wire [15:0] rise_p  = rise & ~bc_q;
  wire [15:0] rise_b  = rise & bc_q;
  wire [3:0]  idx     = bus_addr[5:2];
  wire        aligned = (bus_addr[1:0] == 2'b00);

  assign clr_w = (wr_en && bus_addr == 8'h0C) ? wd : 16'h0;

  always_comb begin
    ack_any = '0;
    for (int c = 0; c < NCPU; c++) begin
      ack_oh[c] = ack_valid[c] ? ((16'h1 << ack_num[c*4 +: 4]) & LMASK) : 16'h0;
      ack_any   = ack_any | ack_oh[c];
    end
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      frc_d[c] = frc_q[c];
      if (c == 0 && wr_en && bus_addr == 8'h08) frc_d[c] = wd;
      if (wr_en && aligned && bus_addr[7:6] == 2'b10 && int'(idx) == c)
        frc_d[c] = (frc_d[c] | wd) & ~wclr;
      frc_d[c] = (frc_d[c] & ~ack_oh[c]) | rise_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      pend_q <= '0;
      bc_q   <= '0;
      irq_q  <= '0;
      for (int c = 0; c < NCPU; c++) begin
        msk_q[c] <= '0;
        frc_q[c] <= '0;
        ext_q[c] <= '0;
      end
    end else begin
      irq_q  <= irq_in;
      pend_q <= (pend_q & ~clr_w & ~ack_any) | rise_p;
      if (wr_en && bus_addr == 8'h00) lvl_q <= wd;
      if (wr_en && bus_addr == 8'h14) bc_q <= wd;
      for (int c = 0; c < NCPU; c++) begin
        frc_q[c] <= frc_d[c];
        if (wr_en && aligned && int'(idx) == c) begin
          if (bus_addr[7:6] == 2'b01) msk_q[c] <= wd;
          if (bus_addr[7:6] == 2'b11) ext_q[c] <= bus_wdata[3:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        8'h00: bus_rdata = {16'h0, lvl_q};
        8'h04: bus_rdata = {16'h0, pend_q};
        8'h08: bus_rdata = {16'h0, frc_q[0]};
        8'h14: bus_rdata = {16'h0, bc_q};
        default: begin
          for (int c = 0; c < NCPU; c++) begin
            if (aligned && int'(idx) == c) begin
              case (bus_addr[7:6])
                2'b01:   bus_rdata = {16'h0, msk_q[c]};
                2'b10:   bus_rdata = {16'h0, frc_q[c]};
                2'b11:   bus_rdata = {28'h0, ext_q[c]};
                default: bus_rdata = '0;
              endcase
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      logic [15:0] hi, pick;
      act_w[c] = (pend_q | frc_q[c]) & msk_q[c];
      hi   = act_w[c] & lvl_q;
      pick = (hi != 16'h0) ? hi : act_w[c];
      cpu_level[c*4 +: 4] = 4'd0;
      for (int i = 1; i < 16; i++)
        if (pick[i]) cpu_level[c*4 +: 4] = 4'(i);
    end
  end

  p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] == 1'b0) && (lvl_q[0] == 1'b0) && (bc_q[0] == 1'b0));

  p_req_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_p != 16'h0) |=> ((pend_q & $past(rise_p)) == $past(rise_p)));

  p_pend_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == 8'h04 && rise_p == 16'h0 && ack_any == 16'h0) |=> $stable(pend_q));

  p_edge_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == 16'h0 && clr_w == 16'h0 && ack_any == 16'h0) |=> $stable(pend_q));

  for (genvar g = 0; g < NCPU; g++) begin : g_chk
    p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid[g] && ((rise & ack_oh[g]) == 16'h0))
        |=> ((pend_q & $past(ack_oh[g])) == 16'h0) && ((frc_q[g] & $past(ack_oh[g])) == 16'h0));

    p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_b != 16'h0) |=> ((frc_q[g] & $past(rise_b)) == $past(rise_b)));

    p_tier_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_w[g] & lvl_q) != 16'h0) |-> lvl_q[cpu_level[g*4 +: 4]]);

    p_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_level[g*4 +: 4] != 4'd0) |-> act_w[g][cpu_level[g*4 +: 4]]);
  end
endmodule

// File: tb/tier_irq_ctrl_tb.sv
module tier_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;

  logic clk = 0, rst_n = 0;
  logic [15:0] irq_in = '0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] ack_valid = '0;
  logic [N*4-1:0] ack_num = '0;
  logic [N*4-1:0] cpu_level;

  int checks = 0, failures = 0;
  logic [15:0] m_lvl, m_pend, m_bc, m_irq;
  logic [15:0] m_msk [N];
  logic [15:0] m_frc [N];
  logic [3:0]  m_ext [N];

  tier_irq_ctrl #(.NCPU(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_num(ack_num), .cpu_level(cpu_level));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] f_lvl(logic [15:0] act, logic [15:0] l);
    logic [15:0] s = ((act & l) != 0) ? (act & l) : (act & ~l);
    logic [3:0] r = 0;
    for (int i = 1; i < 16; i++) if (s[i]) r = 4'(i);
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return {16'h0, m_lvl};
      8'h04: return {16'h0, m_pend};
      8'h08: return {16'h0, m_frc[0]};
      8'h14: return {16'h0, m_bc};
      8'h40: return {16'h0, m_msk[0]};
      8'h44: return {16'h0, m_msk[1]};
      8'h80: return {16'h0, m_frc[0]};
      8'h84: return {16'h0, m_frc[1]};
      8'hC0: return {28'h0, m_ext[0]};
      8'hC4: return {28'h0, m_ext[1]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R3";
      8'h08: return "R8";
      8'h14: return "R4";
      8'h40, 8'h44: return "R5";
      8'h80, 8'h84: return "R7";
      8'hC0, 8'hC4: return "R12";
      default: return "R10";
    endcase
  endfunction

  task automatic step(bit s, bit w, logic [7:0] a, logic [31:0] d, string tag);
    logic [15:0] rise, wd, wc, ackall, f;
    logic [15:0] ackm [N];
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    if (s && !w) chk(tag == "" ? rtag(a) : tag, bus_rdata, m_read(a));
    @(posedge clk);
    rise = irq_in & ~m_irq & 16'hFFFE;
    wd = d[15:0] & 16'hFFFE;
    wc = d[31:16] & 16'hFFFE;
    ackall = 0;
    for (int c = 0; c < N; c++) begin
      ackm[c] = ack_valid[c] ? ((16'h1 << ack_num[c*4 +: 4]) & 16'hFFFE) : 16'h0;
      ackall |= ackm[c];
    end
    m_pend = (m_pend & ~((s && w && a == 8'h0C) ? wd : 16'h0) & ~ackall) | (rise & ~m_bc);
    for (int c = 0; c < N; c++) begin
      f = m_frc[c];
      if (s && w && c == 0 && a == 8'h08) f = wd;
      if (s && w && a == 8'(8'h80 + 4*c)) f = (f | wd) & ~wc;
      m_frc[c] = (f & ~ackm[c]) | (rise & m_bc);
      if (s && w && a == 8'(8'h40 + 4*c)) m_msk[c] = wd;
      if (s && w && a == 8'(8'hC0 + 4*c)) m_ext[c] = d[3:0];
    end
    if (s && w && a == 8'h00) m_lvl = wd;
    if (s && w && a == 8'h14) m_bc = wd;
    m_irq = irq_in;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; ack_valid = '0;
    for (int c = 0; c < N; c++) begin
      logic [15:0] act = (m_pend | m_frc[c]) & m_msk[c];
      chk(((act & m_lvl) != 0) ? "R6 level" : "R5 level",
          {28'h0, cpu_level[c*4 +: 4]}, {28'h0, f_lvl(act, m_lvl)});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] alist [17] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h40, 8'h44,
                               8'h80, 8'h84, 8'hC0, 8'hC4, 8'h18, 8'h3C, 8'h48, 8'h41, 8'hC8};
    m_lvl = 0; m_pend = 0; m_bc = 0; m_irq = 0;
    for (int c = 0; c < N; c++) begin m_msk[c] = 0; m_frc[c] = 0; m_ext[c] = 0; end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int i = 0; i < 17; i++) step(1, 0, alist[i], 0, "R1");
    chk("R1 level", {24'h0, cpu_level}, 32'h0);
    // R6 / R5 directed tier test
    step(1, 1, 8'h40, 32'hFFFF_FFFF, "");
    step(1, 1, 8'h08, 32'h0000_0209, "");
    step(1, 1, 8'h00, 32'h0000_0008, "");
    chk("R6 tier", {28'h0, cpu_level[3:0]}, 32'd3);
    step(1, 1, 8'h00, 32'h0, "");
    chk("R5 highest", {28'h0, cpu_level[3:0]}, 32'd9);
    step(1, 0, 8'h08, 0, "R2");
    // R9: request beats clear in the same cycle
    irq_in = 16'h0020;
    step(1, 1, 8'h0C, 32'h0000_0020, "");
    step(1, 0, 8'h04, 0, "R9");
    chk("R9 req wins", {16'h0, m_pend & 16'h0020}, 32'h20);
    step(1, 1, 8'h0C, 32'h0000_0020, "");
    step(1, 0, 8'h04, 0, "R9");
    // R11: acknowledge cpu0 line 9
    ack_valid = 2'b01; ack_num = 8'h09;
    step(0, 0, 0, 0, "");
    step(1, 0, 8'h08, 0, "R11");
    irq_in = 0;
    // R4: broadcast line 7
    step(1, 1, 8'h14, 32'h0000_0080, "");
    irq_in = 16'h0080;
    step(0, 0, 0, 0, "");
    step(1, 0, 8'h84, 0, "R4");
    step(1, 0, 8'h04, 0, "R4");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom;
      if (r % 4 == 0) irq_in = irq_in ^ (16'h1 << (1 + ($urandom % 15)));
      if ($urandom % 5 == 0) begin
        ack_valid = 2'($urandom);
        ack_num = 8'($urandom);
      end
      if ($urandom % 2 == 0)
        step(1, 1'($urandom), alist[$urandom % 17], $urandom, "");
      else
        step(0, 0, 0, 0, "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule